// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the pin timing for an 8-bit controller core that reaches external memory over a multiplexed bus. One byte-wide port carries the low address byte and then the data byte. A separate port carries the high address byte. An address strobe pulse tells an external latch when to capture the low address. Active-low read and write strobes frame each data-memory transfer. The core gives a code address for every fetch slot and can raise a data request. A data request uses either a full 16-bit pointer or an 8-bit register-indirect address.

A machine cycle lasts 12 clocks. It splits into two slots of six clocks each. Slot A covers clocks 0..5 of the cycle and slot B covers clocks 6..11. The slot-local count `lc` runs from 0 to 5. In each slot where a code fetch runs, the address strobe fires once, so with no data traffic it pulses once every six clocks. A data access takes over slot B of the cycle in which it is accepted, and slot A of the next cycle. No address strobe fires in that second slot, so the strobe misses exactly one pulse for each data access. In register-indirect mode the high port keeps showing the value of the core's high-port output register, and the pointer's upper byte is not used.

Top module: `extbus_seq`

## Requirements
- R1: Once reset is released, the first clock starts slot A with `lc`=0. In a fetch slot `addr_strobe` is high for `lc` 0..1, so with no data traffic it rises every 6 clocks and stays high for 2 clocks.
- R2: A data access uses two consecutive slots: the first starts with an address strobe and the second has none. Exactly one strobe pulse is missing per access, and the slot after the second one is an ordinary fetch.
- R3: For `lc` 0..2 of every slot that carries an address strobe, `ad_oe`=1 and `ad_out` is the low address byte. The byte is therefore still driven and unchanged in the clock after the strobe falls.
- R4: In a fetch slot, `a_hi` is bits 15:8 of the code address. `ad_in` is sampled at `lc`=5. `code_vld` is high for the single clock `lc`=0 of the next slot, with `code_data` holding the sampled byte, and is low at every other time.
- R5: When `d_mode`=0 (16-bit pointer), `a_hi` shows `d_addr[15:8]` through both slots of the data access.
- R6: When `d_mode`=1 (8-bit indirect), `a_hi` shows `hi_out_reg` through both slots of the access, and the low address byte is `d_addr[7:0]`.
- R7: For a write (`d_we`=1), `wr_n` is low from `lc` 4 of the first slot through `lc` 3 of the second slot. `ad_oe`=1 with `ad_out`=`d_wdata` from `lc` 3 of the first slot through `lc` 4 of the second, so the data is valid one clock before the strobe falls and one clock after it rises.
- R8: For a read (`d_we`=0), `rd_n` is low over the same window as the write strobe in R7, and `ad_oe`=0 outside the address phase. `ad_in` is sampled at `lc`=3 of the second slot. `d_done` is high for the single clock `lc`=4 of the second slot, with `d_rdata` holding the sampled byte. For a write, `d_done` pulses in the same clock.
- R9: `rd_n` and `wr_n` are high outside their windows and are never low together. Whenever the bus is driven, all eight bits are driven, so a 1 is driven high and never left floating.
- R10: `dreq` is sampled only on the clock edge that ends `lc`=5 of slot A. A request raised after that edge waits one full cycle, and its slot B stays a fetch.
- R11: While `rst`=1, `addr_strobe`=0, `ad_oe`=0, `rd_n`=`wr_n`=1, `code_vld`=0 and `d_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_addr | input | 16 | Fetch address, captured at each slot boundary |
| code_vld | output | 1 | Fetched byte valid pulse |
| code_data | output | 8 | Fetched byte |
| dreq | input | 1 | Data access request (level) |
| d_we | input | 1 | 1 = write, 0 = read |
| d_mode | input | 1 | 0 = 16-bit pointer, 1 = 8-bit indirect |
| d_addr | input | 16 | Data address |
| d_wdata | input | 8 | Write data |
| d_done | output | 1 | Data access complete pulse |
| d_rdata | output | 8 | Read data |
| hi_out_reg | input | 8 | Core's high-port output register |
| addr_strobe | output | 1 | Address latch enable |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable of the multiplexed bus |
| ad_in | input | 8 | Multiplexed bus input |
| a_hi | output | 8 | High address port |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench goes after the following corner cases.
- **Late requests.** A request raised just after the mid-cycle sampling edge must wait. A design that samples `dreq` on every edge would start a data slot one cycle early, and the strobe pattern would disagree with the expected schedule.
- **Missing strobe pulse.** The bench checks that exactly one strobe pulse is absent per access. A design that drops the pulse in the wrong slot, or drops none, would latch a stale or wrong low address in the memory model.
- **High-port source.** Indirect accesses use an unusual high-port value against a pointer address with a different upper byte. A design that confuses the two sources would address the wrong location or return wrong read data.
- **Bus drive around the strobes.** Writes of all-ones data to address FFFFh check that the bus is fully driven around the write strobe. A design that releases the bus too early would lose the data at the strobe's rising edge.
- **Read timing.** Reads check that the bus is released and that data is sampled while `rd_n` is still low. A read sampled one clock late returns code bytes instead of the stored data.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    localparam int XB_ADDR_W    = 16;
    localparam int XB_DATA_W    = 8;
    localparam int XB_HI_W      = XB_ADDR_W - XB_DATA_W;
    localparam int XB_PHASES    = 2;
    localparam int XB_STATES    = 6;
    localparam int XB_SLOT_CLKS = (XB_STATES / 2) * XB_PHASES;
    localparam int XB_LC_W      = $clog2(XB_SLOT_CLKS);

    typedef logic [XB_LC_W-1:0] lc_t;

    // slot-local windows, all derived from the phase count
    localparam lc_t LC_LAST      = lc_t'(XB_SLOT_CLKS - 1);
    localparam lc_t LC_ALE_END   = lc_t'(XB_PHASES - 1);
    localparam lc_t LC_ADDR_END  = lc_t'(XB_PHASES);
    localparam lc_t LC_WDAT_ON   = lc_t'(XB_PHASES + 1);
    localparam lc_t LC_STRB_ON   = lc_t'(2 * XB_PHASES);
    localparam lc_t LC_STRB_OFF  = lc_t'(2 * XB_PHASES - 1);
    localparam lc_t LC_WHOLD_END = lc_t'(2 * XB_PHASES);
    localparam lc_t LC_ZERO      = lc_t'(0);

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_FETCH = 2'd1,
        SLOT_DAT1  = 2'd2,
        SLOT_DAT2  = 2'd3
    } slot_e;

    typedef enum logic {
        AM_PTR16 = 1'b0,
        AM_REG8  = 1'b1
    } amode_e;

    typedef struct packed {
        logic                 we;
        amode_e               mode;
        logic [XB_ADDR_W-1:0] addr;
        logic [XB_DATA_W-1:0] wdata;
    } xreq_t;

    typedef struct packed {
        logic                 ale;
        logic                 oe;
        logic [XB_DATA_W-1:0] ad;
        logic [XB_HI_W-1:0]   hi;
        logic                 rd_n;
        logic                 wr_n;
    } pins_t;

    function automatic logic lc_in(lc_t lc, lc_t lo, lc_t hi);
        return (lc >= lo) && (lc <= hi);
    endfunction

endpackage

// File: rtl/extbus_timebase.sv
module extbus_timebase
    import extbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output lc_t  lc,
    output logic half_b,
    output logic slot_end
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lc     <= LC_LAST;
            half_b <= 1'b1;
        end else if (lc == LC_LAST) begin
            lc     <= LC_ZERO;
            half_b <= ~half_b;
        end else begin
            lc     <= lc + lc_t'(1);
        end
    end

    assign slot_end = (lc == LC_LAST);

    AST_LC_RANGE: assert property (@(posedge clk) disable iff (rst)
        lc <= LC_LAST);                                         // R1

    AST_LC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (lc == LC_LAST) |=> (lc == LC_ZERO) && (half_b != $past(half_b))); // R1

endmodule

// File: rtl/extbus_slot_ctrl.sv
module extbus_slot_ctrl
    import extbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 half_b,
    input  logic                 slot_end,
    input  logic                 dreq,
    input  xreq_t                req_in,
    input  logic [XB_ADDR_W-1:0] code_addr,
    output slot_e                kind,
    output xreq_t                cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= SLOT_IDLE;
            cur  <= '0;
        end else if (slot_end) begin
            if (!half_b && dreq) begin
                // mid-cycle: the data access replaces the second fetch
                kind <= SLOT_DAT1;
                cur  <= req_in;
            end else if (half_b && kind == SLOT_DAT1) begin
                // cycle boundary: the access keeps the first fetch slot
                kind <= SLOT_DAT2;
            end else begin
                kind      <= SLOT_FETCH;
                cur.we    <= 1'b0;
                cur.mode  <= AM_PTR16;
                cur.addr  <= code_addr;
            end
        end
    end

    AST_DATA_PAIR: assert property (@(posedge clk) disable iff (rst)
        (kind == SLOT_DAT1 && slot_end) |=> (kind == SLOT_DAT2)); // R2

    AST_DATA_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
        (kind == SLOT_DAT1) |-> half_b);                          // R10

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (kind == SLOT_DAT2) |-> $stable(cur));                    // R5

endmodule

// File: rtl/extbus_pins.sv
module extbus_pins
    import extbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  slot_e              kind,
    input  lc_t                lc,
    input  xreq_t              cur,
    input  logic [XB_HI_W-1:0] hi_reg,
    output pins_t              pins
);

    logic is_data;
    logic in_strb;

    assign is_data = (kind == SLOT_DAT1) || (kind == SLOT_DAT2);
    assign in_strb = ((kind == SLOT_DAT1) && lc_in(lc, LC_STRB_ON, LC_LAST)) ||
                     ((kind == SLOT_DAT2) && lc_in(lc, LC_ZERO, LC_STRB_OFF));

    always_comb begin
        pins      = '0;
        pins.rd_n = 1'b1;
        pins.wr_n = 1'b1;
        if (is_data && cur.mode == AM_REG8)
            pins.hi = hi_reg;
        else if (kind == SLOT_IDLE)
            pins.hi = hi_reg;
        else
            pins.hi = cur.addr[XB_ADDR_W-1:XB_DATA_W];

        unique case (kind)
            SLOT_FETCH, SLOT_DAT1: begin
                pins.ale = lc_in(lc, LC_ZERO, LC_ALE_END);
                if (lc_in(lc, LC_ZERO, LC_ADDR_END)) begin
                    pins.oe = 1'b1;
                    pins.ad = cur.addr[XB_DATA_W-1:0];
                end else if (kind == SLOT_DAT1 && cur.we &&
                             lc_in(lc, LC_WDAT_ON, LC_LAST)) begin
                    pins.oe = 1'b1;
                    pins.ad = cur.wdata;
                end
            end
            SLOT_DAT2: begin
                if (cur.we && lc_in(lc, LC_ZERO, LC_WHOLD_END)) begin
                    pins.oe = 1'b1;
                    pins.ad = cur.wdata;
                end
            end
            default: ;
        endcase

        if (in_strb) begin
            if (cur.we) pins.wr_n = 1'b0;
            else        pins.rd_n = 1'b0;
        end
    end

    AST_ALE_RISE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.ale) |=> pins.ale);                              // R1

    AST_ALE_MAX_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (pins.ale && $past(pins.ale)) |=> !pins.ale);               // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.ale) |-> pins.oe && $stable(pins.ad));           // R3

    AST_STROBE_NO_ALE: assert property (@(posedge clk) disable iff (rst)
        (!pins.rd_n || !pins.wr_n) |-> !pins.ale);                  // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        pins.rd_n || pins.wr_n);                                    // R9

    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !pins.wr_n |-> pins.oe);                                    // R7

    AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!pins.wr_n && $past(!pins.wr_n)) |-> $stable(pins.ad));    // R7

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.wr_n) |-> pins.oe && $stable(pins.ad));          // R7

    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !pins.rd_n |-> !pins.oe);                                   // R8

endmodule

// File: rtl/extbus_capture.sv
module extbus_capture
    import extbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  slot_e                kind,
    input  lc_t                  lc,
    input  logic                 cur_we,
    input  logic                 rd_n,
    input  logic [XB_DATA_W-1:0] ad_in,
    output logic                 code_vld,
    output logic [XB_DATA_W-1:0] code_data,
    output logic                 d_done,
    output logic [XB_DATA_W-1:0] d_rdata
);

    logic take_code;
    logic take_data;

    assign take_code = (kind == SLOT_FETCH) && (lc == LC_LAST);
    assign take_data = (kind == SLOT_DAT2) && (lc == LC_STRB_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_vld  <= 1'b0;
            code_data <= '0;
            d_done    <= 1'b0;
            d_rdata   <= '0;
        end else begin
            code_vld <= take_code;
            d_done   <= take_data;
            if (take_code)
                code_data <= ad_in;
            if (take_data && !cur_we)
                d_rdata <= ad_in;
        end
    end

    AST_RD_SAMPLE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (take_data && !cur_we) |-> !rd_n);                          // R8

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        d_done |-> rd_n && !code_vld);                              // R8

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
    import extbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] code_addr,
    output logic        code_vld,
    output logic [7:0]  code_data,
    input  logic        dreq,
    input  logic        d_we,
    input  logic        d_mode,
    input  logic [15:0] d_addr,
    input  logic [7:0]  d_wdata,
    output logic        d_done,
    output logic [7:0]  d_rdata,
    input  logic [7:0]  hi_out_reg,
    output logic        addr_strobe,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic [7:0]  a_hi,
    output logic        rd_n,
    output logic        wr_n
);

    lc_t   lc;
    logic  half_b;
    logic  slot_end;
    slot_e kind;
    xreq_t cur;
    xreq_t req_in;
    pins_t pins;

    assign req_in.we    = d_we;
    assign req_in.mode  = amode_e'(d_mode);
    assign req_in.addr  = d_addr;
    assign req_in.wdata = d_wdata;

    extbus_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .lc       (lc),
        .half_b   (half_b),
        .slot_end (slot_end)
    );

    extbus_slot_ctrl u_slot (
        .clk       (clk),
        .rst       (rst),
        .half_b    (half_b),
        .slot_end  (slot_end),
        .dreq      (dreq),
        .req_in    (req_in),
        .code_addr (code_addr),
        .kind      (kind),
        .cur       (cur)
    );

    extbus_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .lc     (lc),
        .cur    (cur),
        .hi_reg (hi_out_reg),
        .pins   (pins)
    );

    extbus_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .lc        (lc),
        .cur_we    (cur.we),
        .rd_n      (pins.rd_n),
        .ad_in     (ad_in),
        .code_vld  (code_vld),
        .code_data (code_data),
        .d_done    (d_done),
        .d_rdata   (d_rdata)
    );

    assign addr_strobe = pins.ale;
    assign ad_out      = pins.ad;
    assign ad_oe       = pins.oe;
    assign a_hi        = pins.hi;
    assign rd_n        = pins.rd_n;
    assign wr_n        = pins.wr_n;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !addr_strobe && !ad_oe && rd_n && wr_n);    // R11

endmodule

// File: tb/extbus_seq_tb.sv
`timescale 1ns/1ps
module extbus_seq_tb_top;

    localparam int RUN_CLKS = 4800;
    localparam int K_NONE = 0;
    localparam int K_F    = 1;
    localparam int K_D1   = 2;
    localparam int K_D2   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] code_addr = 16'h0000;
    logic        code_vld;
    logic [7:0]  code_data;
    logic        dreq = 1'b0;
    logic        d_we = 1'b0;
    logic        d_mode = 1'b0;
    logic [15:0] d_addr = 16'h0000;
    logic [7:0]  d_wdata = 8'h00;
    logic        d_done;
    logic [7:0]  d_rdata;
    logic [7:0]  hi_out_reg = 8'h00;
    logic        addr_strobe;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in;
    logic [7:0]  a_hi;
    logic        rd_n;
    logic        wr_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    always #4 clk = ~clk;

    extbus_seq dut_i (
        .clk(clk), .rst(rst), .code_addr(code_addr), .code_vld(code_vld),
        .code_data(code_data), .dreq(dreq), .d_we(d_we), .d_mode(d_mode),
        .d_addr(d_addr), .d_wdata(d_wdata), .d_done(d_done), .d_rdata(d_rdata),
        .hi_out_reg(hi_out_reg), .addr_strobe(addr_strobe), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .rd_n(rd_n), .wr_n(wr_n)
    );

    // ---------------- external memory model ----------------
    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return (a[15:8] + {a[3:0], a[7:4]}) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] data_byte(input logic [15:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hC3;
    endfunction

    logic [7:0]  lat_lo = 8'h00;
    bit          armed  = 0;
    int          wr_cnt = 0;
    logic [15:0] wr_addr = 16'h0;
    logic [7:0]  wr_dat  = 8'h0;

    always @(negedge addr_strobe) lat_lo = ad_out;

    always @(posedge wr_n) begin
        if (armed) begin
            wr_addr = {a_hi, lat_lo};
            wr_dat  = ad_out;
            wr_cnt++;
        end
    end

    assign ad_in = (!rd_n) ? data_byte({a_hi, lat_lo}) : code_byte({a_hi, lat_lo});

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic exp_pins(input int k, input int lc, input bit we, input bit md,
                            input logic [15:0] ad, input logic [7:0] wd,
                            input logic [7:0] hr,
                            output bit e_ale, output bit e_oe,
                            output logic [7:0] e_out, output logic [7:0] e_hi,
                            output bit e_rd, output bit e_wr);
        bit strb;
        e_ale = (k == K_F || k == K_D1) && lc <= 1;
        e_oe  = 0;
        e_out = 8'h00;
        if ((k == K_F || k == K_D1) && lc <= 2) begin
            e_oe = 1; e_out = ad[7:0];
        end else if (k == K_D1 && we && lc >= 3) begin
            e_oe = 1; e_out = wd;
        end else if (k == K_D2 && we && lc <= 4) begin
            e_oe = 1; e_out = wd;
        end
        e_hi = ((k == K_D1 || k == K_D2) && md) ? hr : ad[15:8];
        strb = (k == K_D1 && lc >= 4) || (k == K_D2 && lc <= 3);
        e_rd = !(strb && !we);
        e_wr = !(strb && we);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus and checks ----------------
    initial begin
        int          bcnt, lc, ck, pk, op_idx;
        bit          busy, cap_req, cwe, cmd;
        logic [15:0] ca, pa, ef;
        logic [7:0]  cwd, chr;
        bit          e_ale, e_oe, e_rd, e_wr;
        logic [7:0]  e_out, e_hi;
        int          wr_base;
        string       t_ale, t_out, t_hi, t_st;

        void'($urandom(32'd20240611));
        bcnt = 11; ck = K_NONE; pk = K_NONE; op_idx = 0;
        busy = 0; cap_req = 0; cwe = 0; cmd = 0;
        ca = 16'h0; pa = 16'h0; cwd = 8'h0; chr = 8'h0; wr_base = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: quiet pins while in reset
        chk(addr_strobe === 1'b0, "R11", "strobe in reset", addr_strobe, 0);
        chk(ad_oe === 1'b0,       "R11", "oe in reset", ad_oe, 0);
        chk(rd_n === 1'b1 && wr_n === 1'b1, "R11", "rd_n/wr_n in reset", {rd_n, wr_n}, 2'b11);
        chk(code_vld === 1'b0 && d_done === 1'b0, "R11", "vld/done in reset",
            {code_vld, d_done}, 0);
        rst = 1'b0;
        armed = 1;

        for (int n = 0; n < RUN_CLKS; n++) begin
            @(negedge clk);
            bcnt = (bcnt + 1) % 12;
            lc = bcnt % 6;

            if (lc == 0) begin
                pk = ck; pa = ca;
                if (bcnt == 6 && cap_req) begin
                    ck = K_D1; ca = d_addr; cwe = d_we; cmd = d_mode;
                    cwd = d_wdata; chr = hi_out_reg; wr_base = wr_cnt;
                end else if (bcnt == 0 && pk == K_D1) begin
                    ck = K_D2;
                end else begin
                    ck = K_F; ca = code_addr; cwe = 0; cmd = 0;
                end
                // R4: code byte of the previous fetch slot
                if (pk == K_F) begin
                    chk(code_vld === 1'b1, "R4", "code_vld after fetch", code_vld, 1);
                    chk(code_data === code_byte(pa), "R4", "code_data", code_data, code_byte(pa));
                end else begin
                    chk(code_vld === 1'b0, "R4", "code_vld after data slot", code_vld, 0);
                end
            end else begin
                chk(code_vld === 1'b0, "R4", "code_vld mid slot", code_vld, 0);
            end

            exp_pins(ck, lc, cwe, cmd, ca, cwd, chr, e_ale, e_oe, e_out, e_hi, e_rd, e_wr);
            t_ale = (ck == K_D2) ? "R2" : (ck == K_D1 ? "R10" : "R1");
            t_out = (lc <= 2 && ck != K_D2) ? "R3" : "R7";
            t_hi  = (ck == K_F) ? "R4" : (cmd ? "R6" : "R5");
            t_st  = (ck == K_F) ? "R9" : (cwe ? "R7" : "R8");

            chk(addr_strobe === e_ale, t_ale, "addr_strobe", addr_strobe, e_ale);
            chk(ad_oe === e_oe, (ck != K_F && !cwe) ? "R8" : t_out, "ad_oe", ad_oe, e_oe);
            if (e_oe) begin
                chk(ad_out === e_out, t_out, "ad_out", ad_out, e_out);
                if (e_out == 8'hFF)
                    chk(ad_out === 8'hFF && ad_oe === 1'b1, "R9", "ones driven", ad_out, 8'hFF);
            end
            chk(a_hi === e_hi, t_hi, "a_hi", a_hi, e_hi);
            chk(rd_n === e_rd, t_st, "rd_n", rd_n, e_rd);
            chk(wr_n === e_wr, t_st, "wr_n", wr_n, e_wr);
            chk(rd_n === 1'b1 || wr_n === 1'b1, "R9", "strobes exclusive", {rd_n, wr_n}, 2'b11);

            // R8 completion, R7 memory write seen
            if (ck == K_D2 && lc == 4) begin
                ef = cmd ? {chr, ca[7:0]} : ca;
                chk(d_done === 1'b1, "R8", "d_done pulse", d_done, 1);
                if (!cwe) begin
                    chk(d_rdata === data_byte(ef), "R8", "d_rdata", d_rdata, data_byte(ef));
                end else begin
                    chk(wr_cnt == wr_base + 1, "R7", "write count", wr_cnt, wr_base + 1);
                    chk(wr_addr === ef, cmd ? "R6" : "R5", "write address", wr_addr, ef);
                    chk(wr_dat === cwd, "R7", "write data at strobe rise", wr_dat, cwd);
                end
                busy = 0;
            end else begin
                chk(d_done === 1'b0, "R8", "d_done idle", d_done, 0);
            end

            // ---- drive for next edges ----
            if (bcnt == 5) cap_req = dreq;     // R10: only this edge samples
            if (bcnt == 6 && cap_req) dreq = 1'b0;
            if (lc == 2) code_addr = 16'($urandom);

            if (!busy && (bcnt == 0 || bcnt == 2 || bcnt == 8)) begin
                bit go;
                go = 0;
                case (op_idx)
                    0: if (bcnt == 0) begin   // all-ones write at top address
                        go = 1; d_we = 1; d_mode = 0; d_addr = 16'hFFFF;
                        d_wdata = 8'hFF; hi_out_reg = 8'h3C;
                    end
                    1: if (bcnt == 8) begin   // late request, indirect read (R10, R6)
                        go = 1; d_we = 0; d_mode = 1; d_addr = 16'h7712;
                        d_wdata = 8'h00; hi_out_reg = 8'hA5;
                    end
                    2: if (bcnt == 2) begin   // pointer read (R5)
                        go = 1; d_we = 0; d_mode = 0; d_addr = 16'h8001;
                        hi_out_reg = 8'h11;
                    end
                    3: if (bcnt == 0) begin   // indirect write of zero (R6)
                        go = 1; d_we = 1; d_mode = 1; d_addr = 16'hC3FF;
                        d_wdata = 8'h00; hi_out_reg = 8'h00;
                    end
                    default: if ($urandom % 2 == 0) begin
                        go = 1; d_we = $urandom % 2 == 1; d_mode = $urandom % 2 == 1;
                        d_addr = 16'($urandom); d_wdata = 8'($urandom);
                        hi_out_reg = 8'($urandom);
                    end
                endcase
                if (go) begin
                    dreq = 1'b1; busy = 1; op_idx++;
                end
            end
        end

        chk(op_idx > 20, "R2", "data accesses issued", op_idx, 21);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule